// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an 8-bit SPI master that a host drives through a small register bus. The host sets the clock mode, the bit order and the rate in registers. A write to the data register then sends one byte on MOSI and captures one byte from MISO at the same time. When the byte is done, a status flag is set and an interrupt can be raised. A second read port returns the captured byte.

The block also detects two error cases. A write collision occurs when the data register is written while a byte is still shifting. A mode fault occurs when the slave-select input is pulled low while the block acts as master and is not driving that pin itself. All three flags share one clearing rule: the host reads the status register while a flag is up, and then accesses the data register.

The slave-select pin is driven in one of two ways. It can follow the frame automatically, or it can follow a bit in a port register. A direction register tells the pad logic which pins are outputs.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, every register reads 0 except the port register, which reads 0x08. `ss_n_o` is high, `sck_o`, `mosi_o` and `irq` are low, and `pin_dir_o` is 0.
- R2: The registers sit at these offsets. Control at 0x00 reads back all 8 bits. Auxiliary control at 0x01 reads back all 8 bits. Rate at 0x04 keeps bits 6:4 and 2:0 and reads the other bits as 0. Port at 0x0D keeps only bit 3. Direction at 0x10 keeps bits 3:0, which appear on `pin_dir_o` (bit 1 MOSI, bit 2 SCK, bit 3 SS; 0x0E makes all three outputs). Unmapped offsets and idle cycles read 0.
- R3: The control bits are assigned as follows: bit 7 interrupt enable, bit 6 block enable, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bit 1 automatic slave-select, bit 0 LSB first.
- R4: One SCK half-period lasts (L+1)·2^E bus clocks, where L is rate bits 6:4 and E is rate bits 2:0. A frame lasts 16 half-periods, so the full SCK divisor is (L+1)·2^(E+1). Between frames, SCK rests at the polarity bit.
- R5: With phase 0, the first data bit is on MOSI from the start of the frame and changes on each trailing edge. With phase 1, MOSI changes on each leading edge after the first. Bit order follows control bit 0. MOSI is low when no frame is running.
- R6: Reading offset 0x09 returns the 8 bits received in the last completed frame, in the configured bit order. Phase 0 samples on leading edges and phase 1 samples on trailing edges.
- R7: The done flag (status bit 7) is set in the cycle after the frame's last SCK edge.
- R8: A data write while a frame is running sets the collision flag (status bit 6). The written byte is dropped and the running frame continues unchanged.
- R9: The flags clear only when a status read that finds a flag set is followed by a data-register access. A data access without that prior status read leaves the flags unchanged.
- R10: If enable and master are set, automatic slave-select is off, and `ss_n_i` is sampled low, the mode-fault flag (status bit 4) is set. Control bits 6 and 4 are cleared and any running frame stops without setting the done flag.
- R11: `irq` is high exactly when control bit 7 is set and either the done flag or the mode-fault flag is set.
- R12: With master and automatic slave-select both set, `ss_n_o` is low for the duration of a frame. Otherwise `ss_n_o` follows port bit 3.
- R13: A data write while enable or master is clear starts no frame and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle |
| irq | output | 1 | Interrupt request |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | 1 | Slave select out, active low |
| ss_n_i | input | 1 | Slave select sensed, active low |
| pin_dir_o | output | 4 | Pin direction bits |

## Verification
The hardest cases to reach from the ports depend on exact timing inside a running frame. One is a collision, which needs a data write to land while the shifter is busy. The other is a mode fault, which needs the sensed select line to drop in the middle of a byte. The stimulus handles both by running the frame at a slow rate so that there is room to act mid-byte. It then issues a second data write a fixed number of cycles into the frame, and separately pulses `ss_n_i` low for a single cycle. The clearing rule is also checked both ways: once with a data read that has no status read before it, and once with the full status-then-data sequence.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_CTL  = 'h00,
  parameter logic [AW-1:0] A_AUX  = 'h01,
  parameter logic [AW-1:0] A_RATE = 'h04,
  parameter logic [AW-1:0] A_STAT = 'h05,
  parameter logic [AW-1:0] A_DATA = 'h09,
  parameter logic [AW-1:0] A_PIN  = 'h0D,
  parameter logic [AW-1:0] A_DIR  = 'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          ss_n_o,
  input  logic          ss_n_i,
  output logic [3:0]    pin_dir_o
);
  localparam int HW = 11;
  localparam int KW = 5;
  localparam logic [KW-1:0] LAST_EDGE = KW'(16);

  logic [7:0]    ctl, aux, tx_sh, rx_sh, rx_hold;
  logic [2:0]    rate_lin, rate_exp;
  logic          pin_ss;
  logic [3:0]    dir_r;
  logic          busy, done_f, coll_f, flt_f, armed;
  logic [HW-1:0] hc;
  logic [KW-1:0] edge_k;

  wire en   = ctl[6];
  wire mst  = ctl[4];
  wire cpol = ctl[3];
  wire cpha = ctl[2];
  wire ssoe = ctl[1];
  wire lsbf = ctl[0];

  wire rd      = bus_sel & ~bus_wr;
  wire wr      = bus_sel & bus_wr;
  wire data_wr = wr & (bus_addr == A_DATA);
  wire clr     = armed & bus_sel & (bus_addr == A_DATA);
  wire stat_rd = rd & (bus_addr == A_STAT);

  wire [HW-1:0] half = (HW'(rate_lin) + HW'(1)) << rate_exp;
  wire          tick = busy & (hc == half - HW'(1));
  wire [KW-1:0] k_nx = edge_k + KW'(1);
  wire          smp  = tick & (k_nx[0] ^ cpha);
  wire          sft  = tick & ~(k_nx[0] ^ cpha) & (k_nx != LAST_EDGE)
                       & ~(cpha & (k_nx == KW'(1)));
  wire          fin  = tick & (k_nx == LAST_EDGE);
  wire [7:0]    rx_nx = lsbf ? {miso_i, rx_sh[7:1]} : {rx_sh[6:0], miso_i};

  wire mode_flt = en & mst & ~ssoe & ~ss_n_i;
  wire collide  = data_wr & busy;
  wire start    = data_wr & ~busy & en & mst & ~mode_flt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0; aux <= '0; rate_lin <= '0; rate_exp <= '0;
      pin_ss <= 1'b1; dir_r <= '0;
      busy <= 1'b0; hc <= '0; edge_k <= '0;
      tx_sh <= '0; rx_sh <= '0; rx_hold <= '0;
    end else begin
      if (busy) begin
        hc <= tick ? '0 : hc + HW'(1);
        if (tick) edge_k <= k_nx;
        if (smp)  rx_sh <= rx_nx;
        if (sft)  tx_sh <= lsbf ? {1'b0, tx_sh[7:1]} : {tx_sh[6:0], 1'b0};
        if (fin) begin
          busy    <= 1'b0;
          rx_hold <= smp ? rx_nx : rx_sh;
        end
      end
      if (!en || !mst) busy <= 1'b0;
      if (wr) begin
        if (bus_addr == A_CTL) ctl <= bus_wdata;
        if (bus_addr == A_AUX) aux <= bus_wdata;
        if (bus_addr == A_RATE) begin
          rate_lin <= bus_wdata[6:4];
          rate_exp <= bus_wdata[2:0];
        end
        if (bus_addr == A_PIN) pin_ss <= bus_wdata[3];
        if (bus_addr == A_DIR) dir_r <= bus_wdata[3:0];
      end
      if (start) begin
        busy   <= 1'b1;
        hc     <= '0;
        edge_k <= '0;
        tx_sh  <= bus_wdata;
      end
      if (mode_flt) begin
        ctl[6] <= 1'b0;
        ctl[4] <= 1'b0;
        busy   <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_f <= 1'b0; coll_f <= 1'b0; flt_f <= 1'b0; armed <= 1'b0;
    end else begin
      done_f <= fin      | (done_f & ~clr);
      coll_f <= collide  | (coll_f & ~clr);
      flt_f  <= mode_flt | (flt_f  & ~clr);
      if (stat_rd)  armed <= done_f | coll_f | flt_f;
      else if (clr) armed <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_CTL:   bus_rdata = ctl;
        A_AUX:   bus_rdata = aux;
        A_RATE:  bus_rdata = {1'b0, rate_lin, 1'b0, rate_exp};
        A_STAT:  bus_rdata = {done_f, coll_f, 1'b0, flt_f, 4'b0};
        A_DATA:  bus_rdata = rx_hold;
        A_PIN:   bus_rdata = {4'b0, pin_ss, 3'b0};
        A_DIR:   bus_rdata = {4'b0, dir_r};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq       = ctl[7] & (done_f | flt_f);
  assign sck_o     = cpol ^ (busy & edge_k[0]);
  assign mosi_o    = busy & (lsbf ? tx_sh[0] : tx_sh[7]);
  assign ss_n_o    = (mst & ssoe) ? ~busy : pin_ss;
  assign pin_dir_o = dir_r;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int AW = 5,
  parameter logic [AW-1:0] A_DATA = 'h09
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic [AW-1:0] bus_addr,
  input logic          sck_o,
  input logic [7:0]    ctl,
  input logic          busy,
  input logic [4:0]    edge_k,
  input logic          done_f,
  input logic          coll_f,
  input logic          flt_f
);
  // R4
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_o == ctl[3]);

  // R4
  edge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> edge_k < 5'd16);

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_f) |-> $past(busy) && !busy);

  // R8
  coll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_f) |-> $past(busy));

  // R10
  fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flt_f) |-> !ctl[6] && !ctl[4] && !busy);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_f && !(bus_sel && bus_addr == A_DATA)) |=> done_f);
endmodule

bind spi_byte_master spi_byte_master_chk #(.AW(AW), .A_DATA(A_DATA)) u_chk (.*);

// File: tb/spi_byte_master_bench.sv
module spi_byte_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] O_CTL = 5'h00, O_AUX = 5'h01, O_RATE = 5'h04,
                         O_STAT = 5'h05, O_DATA = 5'h09, O_PIN = 5'h0D, O_DIR = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0, bus_sel = 1'b0, bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic miso_i = 1'b0, ss_n_i = 1'b1;
  wire [7:0] bus_rdata;
  wire irq, sck_o, mosi_o, ss_n_o;
  wire [3:0] pin_dir_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [7:0] slave_byte = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_byte_master u_spi_byte_master (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .ss_n_o(ss_n_o), .ss_n_i(ss_n_i), .pin_dir_o(pin_dir_o));

  logic [7:0] m_ctl, m_aux, m_tx, m_slave, m_rxd;
  logic [2:0] m_lin, m_exp;
  logic m_pin;
  logic [3:0] m_dir;
  bit m_busy, m_done, m_coll, m_flt, m_arm;
  int m_n, m_half;

  function automatic int bit_idx(int k, bit ph);
    if (ph) return (k <= 1) ? 0 : (k - 1) / 2;
    return k / 2;
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit ob, en, ms, fl, w, r, clr;
    if (!rst_n) begin
      m_ctl = 0; m_aux = 0; m_lin = 0; m_exp = 0; m_pin = 1; m_dir = 0;
      m_busy = 0; m_done = 0; m_coll = 0; m_flt = 0; m_arm = 0;
      m_n = 0; m_half = 1; m_tx = 0; m_slave = 0; m_rxd = 0;
    end else begin
      ob = m_busy; en = m_ctl[6]; ms = m_ctl[4];
      w = bus_sel && bus_wr; r = bus_sel && !bus_wr;
      fl = en && ms && !m_ctl[1] && !ss_n_i;
      clr = m_arm && bus_sel && bus_addr == O_DATA;
      if (clr) begin m_done = 0; m_coll = 0; m_flt = 0; m_arm = 0; end
      if (r && bus_addr == O_STAT) m_arm = m_done || m_coll || m_flt;
      if (ob) begin
        m_n++;
        if (m_n == 16 * m_half) begin m_busy = 0; m_rxd = m_slave; m_done = 1; end
      end
      if (!en || !ms) m_busy = 0;
      if (w) begin
        case (bus_addr)
          O_CTL:  m_ctl = bus_wdata;
          O_AUX:  m_aux = bus_wdata;
          O_RATE: begin m_lin = bus_wdata[6:4]; m_exp = bus_wdata[2:0]; end
          O_PIN:  m_pin = bus_wdata[3];
          O_DIR:  m_dir = bus_wdata[3:0];
          default: ;
        endcase
      end
      if (w && bus_addr == O_DATA) begin
        if (ob) m_coll = 1;
        else if (en && ms && !fl) begin
          m_busy = 1; m_n = 0; m_half = (int'(m_lin) + 1) << m_exp;
          m_tx = bus_wdata; m_slave = slave_byte;
        end
      end
      if (fl) begin m_flt = 1; m_ctl[6] = 0; m_ctl[4] = 0; m_busy = 0; end
    end
  end

  always @(negedge clk) begin : drive_miso
    int ix;
    ix = bit_idx(m_n / m_half, m_ctl[2]);
    miso_i <= m_busy ? (m_ctl[0] ? m_slave[ix] : m_slave[7-ix]) : 1'b0;
  end

  always begin : compare
    int k, ix;
    logic e_mosi;
    logic [7:0] e_rd;
    @(negedge clk); #(CLK_PERIOD/4);
    if (rst_n && !finished) begin
      k = m_n / m_half;
      ix = bit_idx(k, m_ctl[2]);
      e_mosi = m_busy ? (m_ctl[0] ? m_tx[ix] : m_tx[7-ix]) : 1'b0;
      e_rd = 0;
      if (bus_sel && !bus_wr) begin
        case (bus_addr)
          O_CTL:  e_rd = m_ctl;
          O_AUX:  e_rd = m_aux;
          O_RATE: e_rd = {1'b0, m_lin, 1'b0, m_exp};
          O_STAT: e_rd = {m_done, m_coll, 1'b0, m_flt, 4'b0};
          O_DATA: e_rd = m_rxd;
          O_PIN:  e_rd = {4'b0, m_pin, 3'b0};
          O_DIR:  e_rd = {4'b0, m_dir};
          default: e_rd = 0;
        endcase
      end
      check("R4", "sck", 32'(sck_o), 32'(m_ctl[3] ^ (m_busy && (k % 2 == 1))));
      check("R5", "mosi", 32'(mosi_o), 32'(e_mosi));
      check("R12", "ss_n", 32'(ss_n_o), 32'((m_ctl[4] && m_ctl[1]) ? !m_busy : m_pin));
      check("R11", "irq", 32'(irq), 32'(m_ctl[7] && (m_done || m_flt)));
      check("R2", "pin_dir", 32'(pin_dir_o), 32'(m_dir));
      check("R6", "rdata", 32'(bus_rdata), 32'(e_rd));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #(CLK_PERIOD/4); d = bus_rdata;
    check(req, "read", 32'(d), 32'(exp));
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic frame(input logic [7:0] tx, input logic [7:0] sl, input int half);
    int c;
    slave_byte = sl;
    wr(O_DATA, tx);
    c = 0;
    while (!irq && c < 100000) begin @(negedge clk); c++; end
    check("R4", "frame cycles", 32'(c), 32'(16 * half));
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", "ss_n", 32'(ss_n_o), 32'd1);
    check("R1", "sck", 32'(sck_o), 32'd0);
    check("R1", "irq", 32'(irq), 32'd0);
    rd_chk(O_CTL, 8'h00, "R1");
    rd_chk(O_STAT, 8'h00, "R1");
    rd_chk(O_PIN, 8'h08, "R1");
    rd_chk(O_DIR, 8'h00, "R1");
    // R2 register map
    wr(O_DIR, 8'h0E);
    check("R2", "dir pins", 32'(pin_dir_o), 32'hE);
    wr(O_RATE, 8'hFF);
    rd_chk(O_RATE, 8'h77, "R2");
    wr(O_AUX, 8'h5A);
    rd_chk(O_AUX, 8'h5A, "R2");
    rd_chk(5'h07, 8'h00, "R2");
    // R13 disabled block ignores data write
    wr(O_DATA, 8'h33);
    repeat (10) @(negedge clk);
    rd_chk(O_STAT, 8'h00, "R13");
    // R3 R6 R7 mode 0, MSB first, fastest rate
    wr(O_RATE, 8'h00);
    wr(O_CTL, 8'hD2);
    rd_chk(O_CTL, 8'hD2, "R3");
    frame(8'h3C, 8'hA5, 1);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'hA5, "R6");
    rd_chk(O_STAT, 8'h00, "R9");
    // R8 collision, mode 3, LSB first, half=8
    wr(O_RATE, 8'h12);
    wr(O_CTL, 8'hDF);
    slave_byte = 8'h3B;
    wr(O_DATA, 8'hC1);
    repeat (20) @(negedge clk);
    wr(O_DATA, 8'hFF);
    while (!irq) @(negedge clk);
    // R9 data read without prior status read keeps flags
    rd_chk(O_DATA, 8'h3B, "R8");
    rd_chk(O_STAT, 8'hC0, "R9");
    rd_chk(O_DATA, 8'h3B, "R9");
    rd_chk(O_STAT, 8'h00, "R9");
    // R5 mode 1 MSB first, half=4
    wr(O_RATE, 8'h30);
    wr(O_CTL, 8'hD6);
    frame(8'h7E, 8'h81, 4);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'h81, "R6");
    // R5 mode 2 LSB first, half=2
    wr(O_RATE, 8'h01);
    wr(O_CTL, 8'hDB);
    frame(8'h96, 8'h4D, 2);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'h4D, "R6");
    // R12 manual select through port bit 3
    wr(O_CTL, 8'hD0);
    wr(O_PIN, 8'h00);
    check("R12", "ss manual low", 32'(ss_n_o), 32'd0);
    frame(8'h11, 8'hEE, 2);
    check("R12", "ss manual held", 32'(ss_n_o), 32'd0);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'hEE, "R6");
    wr(O_PIN, 8'h08);
    // R10 mode fault in mid-frame, half=12
    wr(O_RATE, 8'h22);
    slave_byte = 8'h5C;
    wr(O_DATA, 8'hA0);
    repeat (30) @(negedge clk);
    ss_n_i = 0;
    @(negedge clk);
    ss_n_i = 1;
    check("R11", "irq on fault", 32'(irq), 32'd1);
    rd_chk(O_CTL, 8'h80, "R10");
    repeat (200) @(negedge clk);
    rd_chk(O_STAT, 8'h10, "R10");
    rd_chk(O_DATA, 8'hEE, "R10");
    rd_chk(O_STAT, 8'h00, "R9");
    wr(O_DATA, 8'h55);
    repeat (40) @(negedge clk);
    rd_chk(O_STAT, 8'h00, "R13");
    // R11 no interrupt when enable bit clear
    wr(O_RATE, 8'h00);
    wr(O_CTL, 8'h52);
    slave_byte = 8'h0F;
    wr(O_DATA, 8'hF0);
    repeat (40) @(negedge clk);
    check("R11", "irq masked", 32'(irq), 32'd0);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'h0F, "R6");
    // R4 slowest rate
    wr(O_RATE, 8'h77);
    wr(O_CTL, 8'hD2);
    frame(8'hAA, 8'h69, 1024);
    rd_chk(O_STAT, 8'h80, "R7");
    rd_chk(O_DATA, 8'h69, "R6");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule